// File: doc/BRIEF.md
# Serial NOR Flash Command Front-End

This block is the device side of a single-lane serial flash interface. It watches chip select, clock and data-in from an SPI host in either mode 0 or mode 3. It assembles the opcode and any 24-bit address, most significant bit first. It keeps the write-enable latch, the busy flag and the protection settings in a 16-bit status word. Reads of status and identification bytes are driven back on the data-out line, one bit per falling clock edge.

Program, erase and status-write commands are judged when chip select rises. A command that arrives complete, byte-aligned, with the latch set, while the device is idle and outside the protected range produces a one-cycle request carrying a kind code and an address, and the busy flag is set. The memory array beneath the block finishes the work and returns `op_done`. That clears busy and the latch. All SPI pins pass through synchronizers into the system clock `clk`, so the SPI clock must run well below `clk` (at least six `clk` periods per SPI half period).

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: Data-in is shifted on synchronized rising SPI clock edges, MSB first, and the first byte is the opcode. Response bits change only after a falling SPI edge, MSB first. `spi_miso_oe` is 1 only while chip select is low. Both SPI modes 0 and 3 work.
- R2: Opcode 06h sets the write-enable latch (status bit 1) and 04h clears it, each acting when chip select rises after whole bytes.
- R3: Opcodes 01h, 02h, 20h, 52h, D8h, C7h and 60h produce no request while the latch is 0.
- R4: A write-class command whose chip select rises after a partial byte is discarded, and the latch is unchanged.
- R5: An accepted command gives a one-cycle `op_start` with `op_kind` (0 program 02h, 1 erase 20h, 2 erase 52h, 3 erase D8h, 4 chip erase C7h/60h, 5 status write 01h) and the captured address. Busy (status bit 0 and port `busy`) stays 1 until `op_done`, which clears both busy and the latch.
- R6: While busy, every opcode except 05h is ignored: no request, no latch change, and no ID or 35h data (zeros are sent). A chip-select rise seen in the same cycle as `op_done` still counts as arriving while busy.
- R7: 05h returns status bits 7..0 and 35h returns bits 15..8. The byte repeats while chip select stays low.
- R8: 9Fh returns EFh, 40h, 17h, cycling. 90h followed by three address bytes returns EFh, 16h, alternating, when address bit 0 is 0, and the same bytes starting with 16h when it is 1.
- R9: The protection fields are BP = status bits 4..2, TB = bit 5 and SEC = bit 6. BP=000 protects nothing and BP=111 protects everything. With SEC=0, the protected size is 64 KB shifted left by BP, taken from the top when TB=0 or the bottom when TB=1. With SEC=1, BP=001/010/011 protect 4/8/16 KB and BP=10x protects 32 KB, at the same end. Address bit 23 is ignored.
- R10: A program or erase whose address is protected, or a chip erase with BP not 000, produces no request and clears the latch.
- R11: 01h with one data byte writes status bits 7..2. With two data bytes it also writes bits 15..8. Bits 1..0 are never written this way.
- R12: A read stopped after any bit leaves no trace, and the next transaction decodes from a fresh opcode.
- R13: `op_done` while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| op_start | output | 1 | One-cycle request to the array |
| op_kind | output | 3 | Request kind code |
| op_addr | output | 24 | Request address |
| op_done | input | 1 | Array reports the request finished |
| busy | output | 1 | Request in progress |

## Verification
Two events can meet in one `clk` cycle: the array's `op_done`, which ends the busy period and clears the latch, and the synchronized chip-select rise that asks for a new command to be judged. The bench counts the synchronizer stages and places a `op_done` pulse exactly on the cycle in which a write-enable transaction's chip-select rise is detected. It then reads status 05h. The expected value is 00h: busy is gone, and the latch is clear because the coincident 06h was judged against the old busy state and dropped.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    OPK_PROG      = 3'd0,
    OPK_ERASE_4K  = 3'd1,
    OPK_ERASE_32K = 3'd2,
    OPK_ERASE_64K = 3'd3,
    OPK_CHIP      = 3'd4,
    OPK_WRSR      = 3'd5
  } op_kind_e;

  localparam logic [7:0] CMD_WREN    = 8'h06;
  localparam logic [7:0] CMD_WRDI    = 8'h04;
  localparam logic [7:0] CMD_RDST_LO = 8'h05;
  localparam logic [7:0] CMD_RDST_HI = 8'h35;
  localparam logic [7:0] CMD_WRST    = 8'h01;
  localparam logic [7:0] CMD_PROG    = 8'h02;
  localparam logic [7:0] CMD_ER4K    = 8'h20;
  localparam logic [7:0] CMD_ER32K   = 8'h52;
  localparam logic [7:0] CMD_ER64K   = 8'hD8;
  localparam logic [7:0] CMD_CHIP_A  = 8'hC7;
  localparam logic [7:0] CMD_CHIP_B  = 8'h60;
  localparam logic [7:0] CMD_JEDEC   = 8'h9F;
  localparam logic [7:0] CMD_MFDEV   = 8'h90;

  localparam logic [7:0] ID_MFR  = 8'hEF;
  localparam logic [7:0] ID_TYPE = 8'h40;
  localparam logic [7:0] ID_CAP  = 8'h17;
  localparam logic [7:0] ID_DEV  = 8'h16;

endpackage

// File: rtl/spi_fe_sampler.sv
module spi_fe_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic mosi_s
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sck_q, sck_d;
  logic [W-1:0] cs_q, cs_d;
  logic [W-1:0] mosi_q, mosi_d;

  always_comb begin
    sck_d  = {sck_q[W-2:0], sck_i};
    cs_d   = {cs_q[W-2:0], cs_n_i};
    mosi_d = {mosi_q[W-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= sck_d;
      cs_q   <= cs_d;
      mosi_q <= mosi_d;
    end
  end

  assign sck_rise = sck_q[W-2] & ~sck_q[W-1];
  assign sck_fall = ~sck_q[W-2] & sck_q[W-1];
  assign cs_fall  = ~cs_q[W-2] & cs_q[W-1];
  assign cs_rise  = cs_q[W-2] & ~cs_q[W-1];
  assign cs_act   = ~cs_q[W-2];
  assign mosi_s   = mosi_q[W-2];
endmodule

// File: rtl/spi_fe_framer.sv
module spi_fe_framer #(
  parameter int ADDR_W = 24,
  parameter int BCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output logic [2:0]        bit_cnt,
  output logic [BCNT_W-1:0] byte_cnt,
  output logic              byte_done,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        dat0,
  output logic [7:0]        dat1
);
  localparam int ABYTES = ADDR_W / 8;
  localparam logic [BCNT_W-1:0] LAST_ADDR = BCNT_W'(ABYTES);

  logic [6:0]        sh_q, sh_d;
  logic [2:0]        bit_d;
  logic [BCNT_W-1:0] byte_d;
  logic [7:0]        opc_d, d0_d, d1_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        full;

  assign full      = {sh_q, mosi_s};
  assign byte_done = cs_act & sck_rise & (bit_cnt == 3'd7);

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_cnt;
    byte_d = byte_cnt;
    opc_d  = opcode;
    addr_d = addr;
    d0_d   = dat0;
    d1_d   = dat1;
    if (cs_fall) begin
      bit_d  = 3'd0;
      byte_d = '0;
      opc_d  = 8'h00;
    end else if (cs_act && sck_rise) begin
      sh_d  = full[6:0];
      bit_d = bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (byte_cnt != '1) byte_d = byte_cnt + 1'b1;
        if (byte_cnt == '0) opc_d = full;
        if (byte_cnt != '0 && byte_cnt <= LAST_ADDR) addr_d = {addr[ADDR_W-9:0], full};
        if (byte_cnt == BCNT_W'(1)) d0_d = full;
        if (byte_cnt == BCNT_W'(2)) d1_d = full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      addr     <= '0;
      dat0     <= '0;
      dat1     <= '0;
    end else begin
      sh_q     <= sh_d;
      bit_cnt  <= bit_d;
      byte_cnt <= byte_d;
      opcode   <= opc_d;
      addr     <= addr_d;
      dat0     <= d0_d;
      dat1     <= d1_d;
    end
  end
endmodule

// File: rtl/spi_fe_protect.sv
module spi_fe_protect #(
  parameter int MEM_AW = 23
) (
  input  logic              sec,
  input  logic              tb,
  input  logic [2:0]        bp,
  input  logic [MEM_AW-1:0] addr,
  output logic              hit
);
  int unsigned lg;
  logic        lo_hit, hi_hit;

  always_comb begin
    if (sec) begin
      lg = bp[2] ? 32'd15 : 32'd11 + 32'(bp[1:0]);
    end else begin
      lg = 32'(MEM_AW - 7) + 32'(bp);
    end
    lo_hit = ((addr >> lg) == '0);
    hi_hit = (((~addr) >> lg) == '0);
    if (bp == 3'b000)      hit = 1'b0;
    else if (bp == 3'b111) hit = 1'b1;
    else                   hit = tb ? lo_hit : hi_hit;
  end
endmodule

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MEM_AW      = 23,
  parameter int SYNC_STAGES = 2,
  parameter int BCNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  input  logic              op_done,
  output logic              busy
);
  localparam int ABYTES = ADDR_W / 8;
  localparam logic [BCNT_W-1:0] LEN_ONE  = BCNT_W'(1);
  localparam logic [BCNT_W-1:0] LEN_WRST = BCNT_W'(2);
  localparam logic [BCNT_W-1:0] LEN_HI   = BCNT_W'(3);
  localparam logic [BCNT_W-1:0] LEN_ADDR = BCNT_W'(ABYTES + 1);

  logic              sck_rise, sck_fall, cs_fall, cs_rise, cs_act, mosi_s;
  logic [2:0]        bit_cnt;
  logic [BCNT_W-1:0] byte_cnt;
  logic              byte_done;
  logic [7:0]        opc, dat0, dat1;
  logic [ADDR_W-1:0] fr_addr;
  logic              prot_hit;

  logic              st_busy, st_wel, busy_d, wel_d;
  logic [5:0]        st_cfg, cfg_d;
  logic [7:0]        st_hi, hi_d;
  logic              start_q, start_d;
  op_kind_e          kind_q, kind_d, kind_sel;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        id_ph, id_d;
  logic              miso_q, miso_d;
  logic [15:0]       status;
  logic              is_addr_wr, is_chip, is_wrst, take, blocked;
  logic [BCNT_W-1:0] need_len;
  logic [7:0]        tx_byte;
  logic              id_adv, id_wrap;

  spi_fe_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_fe_framer #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_act(cs_act), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .byte_done(byte_done),
    .opcode(opc), .addr(fr_addr), .dat0(dat0), .dat1(dat1)
  );

  spi_fe_protect #(.MEM_AW(MEM_AW)) u_prot (
    .sec(st_cfg[4]), .tb(st_cfg[3]), .bp(st_cfg[2:0]),
    .addr(fr_addr[MEM_AW-1:0]), .hit(prot_hit)
  );

  assign status = {st_hi, st_cfg, st_wel, st_busy};

  // command classification
  always_comb begin
    is_addr_wr = (opc == CMD_PROG) || (opc == CMD_ER4K) || (opc == CMD_ER32K) || (opc == CMD_ER64K);
    is_chip    = (opc == CMD_CHIP_A) || (opc == CMD_CHIP_B);
    is_wrst    = (opc == CMD_WRST);
    case (opc)
      CMD_PROG:  kind_sel = OPK_PROG;
      CMD_ER4K:  kind_sel = OPK_ERASE_4K;
      CMD_ER32K: kind_sel = OPK_ERASE_32K;
      CMD_ER64K: kind_sel = OPK_ERASE_64K;
      CMD_WRST:  kind_sel = OPK_WRSR;
      default:   kind_sel = OPK_CHIP;
    endcase
    need_len = is_addr_wr ? LEN_ADDR : (is_wrst ? LEN_WRST : LEN_ONE);
    blocked  = (is_addr_wr && prot_hit) || (is_chip && (st_cfg[2:0] != 3'b000));
    take     = cs_rise && !st_busy && (bit_cnt == 3'd0);
  end

  // status, latch and request next state
  always_comb begin
    busy_d  = st_busy;
    wel_d   = st_wel;
    cfg_d   = st_cfg;
    hi_d    = st_hi;
    start_d = 1'b0;
    kind_d  = kind_q;
    addr_d  = addr_q;
    if (st_busy && op_done) begin
      busy_d = 1'b0;
      wel_d  = 1'b0;
    end
    if (take) begin
      if (opc == CMD_WREN && byte_cnt >= LEN_ONE) begin
        wel_d = 1'b1;
      end else if (opc == CMD_WRDI) begin
        wel_d = 1'b0;
      end else if ((is_addr_wr || is_chip || is_wrst) && st_wel && byte_cnt >= need_len) begin
        if (blocked) begin
          wel_d = 1'b0;
        end else begin
          start_d = 1'b1;
          busy_d  = 1'b1;
          kind_d  = kind_sel;
          addr_d  = fr_addr;
          if (is_wrst) begin
            cfg_d = dat0[7:2];
            if (byte_cnt >= LEN_HI) hi_d = dat1;
          end
        end
      end
    end
  end

  // response byte and serial output
  always_comb begin
    tx_byte = 8'h00;
    case (opc)
      CMD_RDST_LO: tx_byte = status[7:0];
      CMD_RDST_HI: if (!st_busy) tx_byte = status[15:8];
      CMD_JEDEC:   if (!st_busy) tx_byte = (id_ph == 2'd0) ? ID_MFR : ((id_ph == 2'd1) ? ID_TYPE : ID_CAP);
      CMD_MFDEV:   if (!st_busy && byte_cnt >= LEN_ADDR) tx_byte = (id_ph[0] ^ fr_addr[0]) ? ID_DEV : ID_MFR;
      default:     tx_byte = 8'h00;
    endcase
    id_adv  = byte_done && !st_busy &&
              (((opc == CMD_JEDEC) && byte_cnt >= LEN_ONE) || ((opc == CMD_MFDEV) && byte_cnt >= LEN_ADDR));
    id_wrap = ((opc == CMD_JEDEC) && id_ph == 2'd2) || ((opc == CMD_MFDEV) && id_ph == 2'd1);
    id_d    = id_ph;
    if (cs_fall)     id_d = 2'd0;
    else if (id_adv) id_d = id_wrap ? 2'd0 : id_ph + 2'd1;
    miso_d = miso_q;
    if (cs_fall)                 miso_d = 1'b0;
    else if (cs_act && sck_fall) miso_d = tx_byte[3'd7 - bit_cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_busy <= 1'b0;
      st_wel  <= 1'b0;
      st_cfg  <= '0;
      st_hi   <= '0;
      start_q <= 1'b0;
      kind_q  <= OPK_PROG;
      addr_q  <= '0;
      id_ph   <= '0;
      miso_q  <= 1'b0;
    end else begin
      st_busy <= busy_d;
      st_wel  <= wel_d;
      st_cfg  <= cfg_d;
      st_hi   <= hi_d;
      start_q <= start_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      id_ph   <= id_d;
      miso_q  <= miso_d;
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = cs_act;
  assign op_start    = start_q;
  assign op_kind     = kind_q;
  assign op_addr     = addr_q;
  assign busy        = st_busy;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
  input logic clk,
  input logic rst_n,
  input logic op_start,
  input logic op_done,
  input logic busy,
  input logic wel,
  input logic miso,
  input logic sck_fall,
  input logic cs_fall,
  input logic cs_rise
);
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> (!busy && !wel));

  a_r6_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !op_start);

  a_r3_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> wel);

  a_r2_wel_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> ($past(cs_rise) || ($past(op_done) && $past(busy))));

  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sck_fall) && !$past(cs_fall)) |-> $stable(miso));
endmodule

bind spi_flash_cmd_fe spi_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done), .busy(busy),
  .wel(st_wel), .miso(spi_miso), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
);

// File: tb/test_spi_flash_cmd_fe.sv
module test_spi_flash_cmd_fe;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        op_done = 1'b0;
  logic        spi_miso, spi_miso_oe, op_start, busy;
  logic [2:0]  op_kind;
  logic [23:0] op_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int n_starts = 0;
  logic [2:0]  last_kind = '0;
  logic [23:0] last_addr = '0;
  bit mode3 = 1'b0;
  bit finished = 1'b0;

  spi_flash_cmd_fe i_spi_flash_cmd_fe (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_done(op_done), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (op_start) begin
      n_starts  = n_starts + 1;
      last_kind = op_kind;
      last_addr = op_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin(input bit m3);
    mode3 = m3;
    spi_sck = m3;
    hwait(HALF);
    spi_cs_n = 1'b0;
    hwait(HALF);
  endtask

  task automatic cs_end();
    hwait(HALF);
    spi_cs_n = 1'b1;
    hwait(4 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      if (mode3) spi_sck = 1'b0;
      spi_mosi = tx[i];
      hwait(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      hwait(HALF);
      if (!mode3) spi_sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_begin(1'b0); xb(op, r); cs_end();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    cs_begin(1'b0); xb(op, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); cs_end();
  endtask

  task automatic rd(input logic [7:0] op, output logic [7:0] v);
    logic [7:0] r;
    cs_begin(1'b0); xb(op, r); xb(8'h00, v); cs_end();
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    hwait(2);
  endtask

  task automatic set_status(input logic [7:0] v);
    logic [7:0] r;
    cmd(8'h06);
    cs_begin(1'b0); xb(8'h01, r); xb(v, r); cs_end();
    done_pulse();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 oe idle", spi_miso_oe, 0);
    check("R5 busy reset", busy, 0);
    rd(8'h05, v); check("R7 status lo reset", v, 8'h00);
    rd(8'h35, v); check("R7 status hi reset", v, 8'h00);
    check("R5 no start at reset", n_starts, 0);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    cmd(8'h06); rd(8'h05, v); check("R2 wren", v, 8'h02);
    cmd(8'h04); rd(8'h05, v); check("R2 wrdi", v, 8'h00);
  endtask

  task automatic t_no_wel();
    int s0 = n_starts;
    logic [7:0] v;
    cmd_addr(8'h02, 24'h000100);
    check("R3 no wel no start", n_starts, s0);
    cmd(8'hC7);
    check("R3 chip no wel", n_starts, s0);
    rd(8'h05, v); check("R3 status", v, 8'h00);
  endtask

  task automatic t_unaligned();
    int s0 = n_starts;
    logic [7:0] v, r;
    cmd(8'h06);
    cs_begin(1'b0);
    xb(8'h20, r); xb(8'h00, r); xb(8'h10, r); xb(8'h00, r); xbits(8'hA0, 3, r);
    cs_end();
    check("R4 partial byte dropped", n_starts, s0);
    rd(8'h05, v); check("R4 latch kept", v, 8'h02);
    cmd(8'h04);
  endtask

  task automatic t_busy();
    int s0 = n_starts;
    logic [7:0] v, r, a, b, c;
    cmd(8'h06);
    cmd_addr(8'h20, 24'h012345);
    check("R5 start count", n_starts, s0 + 1);
    check("R5 kind", last_kind, 3'd1);
    check("R5 addr", last_addr, 24'h012345);
    check("R5 busy port", busy, 1);
    cs_begin(1'b0); xb(8'h05, r); xb(8'h00, a); xb(8'h00, b); xb(8'h00, c); cs_end();
    check("R7 repeat 1", a, 8'h03); check("R7 repeat 2", b, 8'h03); check("R7 repeat 3", c, 8'h03);
    cmd(8'h04); rd(8'h05, v); check("R6 wrdi ignored", v, 8'h03);
    rd(8'h9F, v); check("R6 id silent", v, 8'h00);
    cmd_addr(8'hD8, 24'h000000); check("R6 no start busy", n_starts, s0 + 1);
    done_pulse();
    check("R5 busy cleared", busy, 0);
    rd(8'h05, v); check("R5 done clears latch", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v, r;
    cmd(8'h06);
    cmd_addr(8'h02, 24'h000040);
    cs_begin(1'b0); xb(8'h06, r);
    hwait(HALF);
    @(negedge clk); spi_cs_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    hwait(4 * HALF);
    check("R6 collide busy", busy, 0);
    rd(8'h05, v); check("R6 same-cycle cmd dropped", v, 8'h00);
  endtask

  task automatic t_wrst();
    int s0 = n_starts;
    logic [7:0] v, r;
    cmd(8'h06);
    cs_begin(1'b0); xb(8'h01, r); xb(8'h5F, r); xb(8'hA5, r); cs_end();
    check("R11 wrst start", n_starts, s0 + 1);
    check("R5 wrst kind", last_kind, 3'd5);
    done_pulse();
    rd(8'h05, v); check("R11 low bits", v, 8'h5C);
    rd(8'h35, v); check("R11 high byte", v, 8'hA5);
    cmd(8'h06); cmd(8'hC7);
    check("R10 chip erase blocked", n_starts, s0 + 1);
    rd(8'h05, v); check("R10 latch cleared", v, 8'h5C);
    set_status(8'h04);
    rd(8'h05, v); check("R11 one byte low", v, 8'h04);
    rd(8'h35, v); check("R11 one byte keeps high", v, 8'hA5);
  endtask

  task automatic t_protect();
    int s0;
    logic [7:0] v;
    s0 = n_starts;
    cmd(8'h06); cmd_addr(8'h02, 24'h7E0000);
    check("R9 upper 128K hit", n_starts, s0);
    rd(8'h05, v); check("R10 latch cleared", v, 8'h04);
    cmd(8'h06); cmd_addr(8'h02, 24'h7DFFFF);
    check("R9 below upper range", n_starts, s0 + 1);
    check("R5 prog kind", last_kind, 3'd0);
    done_pulse();
    set_status(8'h44); s0 = n_starts;
    cmd(8'h06); cmd_addr(8'h20, 24'h7FF000);
    check("R9 top 4K hit", n_starts, s0);
    cmd(8'h06); cmd_addr(8'h20, 24'h7FEFFF);
    check("R9 top 4K miss", n_starts, s0 + 1);
    done_pulse();
    set_status(8'h24); s0 = n_starts;
    cmd(8'h06); cmd_addr(8'h52, 24'h01FFFF);
    check("R9 lower 128K hit", n_starts, s0);
    cmd(8'h06); cmd_addr(8'h52, 24'h020000);
    check("R9 lower 128K miss", n_starts, s0 + 1);
    check("R5 erase32 kind", last_kind, 3'd2);
    done_pulse();
    set_status(8'h1C); s0 = n_starts;
    cmd(8'h06); cmd_addr(8'hD8, 24'h000000);
    check("R9 all protected", n_starts, s0);
    set_status(8'h00); s0 = n_starts;
    cmd(8'h06); cmd(8'h60);
    check("R5 chip erase accepted", n_starts, s0 + 1);
    check("R5 chip kind", last_kind, 3'd4);
    done_pulse();
  endtask

  task automatic t_ids();
    logic [7:0] r, a, b, c, d;
    for (int m = 0; m < 2; m++) begin
      cs_begin(m[0]);
      check("R1 oe active", spi_miso_oe, 1);
      xb(8'h9F, r); xb(8'h00, a); xb(8'h00, b); xb(8'h00, c); xb(8'h00, d);
      cs_end();
      check("R8 jedec 0", a, 8'hEF); check("R8 jedec 1", b, 8'h40);
      check("R8 jedec 2", c, 8'h17); check("R8 jedec wrap", d, 8'hEF);
    end
    cs_begin(1'b0);
    xb(8'h90, r); xb(8'h00, r); xb(8'h00, r); xb(8'h00, r);
    xb(8'h00, a); xb(8'h00, b); xb(8'h00, c);
    cs_end();
    check("R8 mfdev 0", a, 8'hEF); check("R8 mfdev 1", b, 8'h16); check("R8 mfdev 2", c, 8'hEF);
    cs_begin(1'b1);
    xb(8'h90, r); xb(8'h00, r); xb(8'h00, r); xb(8'h01, r);
    xb(8'h00, a); xb(8'h00, b);
    cs_end();
    check("R8 mfdev swap 0", a, 8'h16); check("R8 mfdev swap 1", b, 8'hEF);
  endtask

  task automatic t_abort();
    logic [7:0] v, r;
    cs_begin(1'b0); xb(8'h9F, r); xbits(8'h00, 3, r); cs_end();
    rd(8'h05, v); check("R12 after aborted read", v, 8'h00);
    cs_begin(1'b0); xbits(8'h35, 5, r); cs_end();
    rd(8'h05, v); check("R12 after aborted opcode", v, 8'h00);
    cmd(8'h06);
    done_pulse();
    check("R13 idle done busy", busy, 0);
    rd(8'h05, v); check("R13 idle done latch", v, 8'h02);
    cmd(8'h04);
  endtask

  initial begin
    hwait(5);
    rst_n = 1'b1;
    hwait(5);
    t_reset();
    t_latch();
    t_no_wel();
    t_unaligned();
    t_busy();
    t_collide();
    t_wrst();
    t_protect();
    t_ids();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule